// File: doc/BRIEF.md
# Tick Counter with Compare Interrupt

This block keeps a free-running tick count that advances by one on every clock. Next to the count it holds a flag that locks out reads of the count from the lowest privilege level. A compare register holds a target value and an interrupt-disable bit. Software reads and writes both registers through a single-cycle access port. The port reports a fault code whenever the privilege level of the access does not allow the operation.

A compare write arms or disarms the interrupt at that moment. The write is armed only when the disable bit is clear and the target value is strictly greater than the count in the write cycle. An armed compare raises a sticky interrupt request once the count reaches the target. The next accepted compare write clears that request. Read data and the fault code are combinational in the access cycle. A write takes effect at the clock edge that ends the access.

Top module: `tick_timer`

## Requirements
- R1: While reset is asserted, the count is 0, the read-lock flag is 0, the compare register reads 0x8000_0000_0000_0000 (disable set, value 0) and irq_o is 0.
- R2: The count advances by exactly one on every clock edge that carries no accepted count write. It wraps from 2^63-1 to 0.
- R3: An accepted count write (sel_i=0, priv_i[1]=1) loads wdata_i[62:0] as the count and wdata_i[63] as the read-lock flag. A count read returns the count in bits 62:0 and the flag in bit 63.
- R4: A count write with priv_i=0 (user) returns fault_o=1 (privileged opcode). A count write with priv_i=1 (supervisor) returns fault_o=2 (privileged action). Neither write changes the count or the flag.
- R5: A count read with priv_i=0 while the read-lock flag is 1 returns fault_o=2 and rdata_o=0. A count read is otherwise allowed with fault_o=0.
- R6: Any compare access (sel_i=1) with priv_i=0 returns fault_o=1 and rdata_o=0, and the write is discarded.
- R7: An accepted compare write with bit 63 (disable) set cancels any armed compare, so that no interrupt follows from it.
- R8: An accepted compare write with bit 63 clear and bits 62:0 greater than the current count arms the compare. irq_o becomes 1 at the edge that ends the cycle in which the count equals the compare value.
- R9: irq_o, once set, stays at 1 until the next accepted compare write, which clears it at that edge.
- R10: An accepted compare write whose value is not greater than the current count arms nothing, and irq_o stays 0.
- R11: A compare read with priv_i of 1 or higher returns the last accepted compare write, disable bit included.
- R12: fault_o is 0 when req_i is 0, and rdata_o is 0 whenever fault_o is non-zero or no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request in this cycle |
| wr_i | input | 1 | 1 = write, 0 = read |
| sel_i | input | 1 | 0 = count register, 1 = compare register |
| priv_i | input | 2 | 0 user, 1 supervisor, 2 or 3 hypervisor |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data, valid in the access cycle |
| fault_o | output | 2 | 0 none, 1 privileged opcode, 2 privileged action |
| irq_o | output | 1 | Sticky compare interrupt request |

## Verification
The assertions expect req_i, wr_i, sel_i, priv_i and wdata_i to be stable around the clock edge, and they expect reset to be released away from an edge. The bench drives every input on the falling edge and releases reset there too. The bench also checks combinational results one time unit after it drives the inputs. Fault-decode rows are applied and then withdrawn before the next rising edge, so that they never commit a write. The compare scenarios load the count first, which keeps target values small and keeps the match window inside a short run.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_OPCODE = 2'd1,
    FLT_ACTION = 2'd2
  } fault_e;

  localparam logic SEL_CNT = 1'b0;
  localparam logic SEL_CMP = 1'b1;
endpackage

// File: rtl/tick_access_ctrl.sv
module tick_access_ctrl
  import tick_timer_pkg::*;
(
  input  logic       req_i,
  input  logic       wr_i,
  input  logic       sel_i,
  input  logic [1:0] priv_i,
  input  logic       lock_i,
  output fault_e     fault_o,
  output logic       cnt_we_o,
  output logic       cmp_we_o,
  output logic       rd_ok_o
);
  logic is_user, is_hyp;
  assign is_user = (priv_i == 2'd0);
  assign is_hyp  = priv_i[1];

  always_comb begin
    fault_o = FLT_NONE;
    if (req_i) begin
      if (sel_i == SEL_CNT) begin
        if (wr_i) begin
          if (is_user)      fault_o = FLT_OPCODE;
          else if (!is_hyp) fault_o = FLT_ACTION;
        end else if (is_user && lock_i) begin
          fault_o = FLT_ACTION;
        end
      end else if (is_user) begin
        fault_o = FLT_OPCODE;
      end
    end
  end

  assign cnt_we_o = req_i && wr_i  && (sel_i == SEL_CNT) && (fault_o == FLT_NONE);
  assign cmp_we_o = req_i && wr_i  && (sel_i == SEL_CMP) && (fault_o == FLT_NONE);
  assign rd_ok_o  = req_i && !wr_i && (fault_o == FLT_NONE);

  always_comb begin
    if (!req_i) AST_IDLE_NO_FAULT: assert (fault_o == FLT_NONE); // R12
  end
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int CNT_W = 63
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CNT_W:0]   wdata_i,
  output logic [CNT_W-1:0] count_o,
  output logic             lock_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '0;
      lock_o  <= 1'b0;
    end else if (we_i) begin
      count_o <= wdata_i[CNT_W-1:0];
      lock_o  <= wdata_i[CNT_W];
    end else begin
      count_o <= count_o + 1'b1;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> (count_o == $past(count_o) + 1'b1) && $stable(lock_o)); // R2
  AST_CNT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (count_o == $past(wdata_i[CNT_W-1:0])) && (lock_o == $past(wdata_i[CNT_W]))); // R3
endmodule

// File: rtl/tick_compare.sv
module tick_compare #(
  parameter int CNT_W = 63
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CNT_W:0]   wdata_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [CNT_W:0]   cmp_o,
  output logic             irq_o
);
  localparam int DIS_BIT = CNT_W;

  logic armed_q;
  logic [CNT_W-1:0] tgt;
  assign tgt = cmp_o[CNT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_o   <= {1'b1, {CNT_W{1'b0}}};
      armed_q <= 1'b0;
      irq_o   <= 1'b0;
    end else if (we_i) begin
      cmp_o   <= wdata_i;
      armed_q <= !wdata_i[DIS_BIT] && (wdata_i[CNT_W-1:0] > count_i);
      irq_o   <= 1'b0;
    end else if (armed_q && (count_i == tgt)) begin
      armed_q <= 1'b0;
      irq_o   <= 1'b1;
    end
  end

  AST_DIS_DISARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wdata_i[DIS_BIT]) |=> !armed_q); // R7
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !we_i) |=> irq_o); // R9
  AST_WR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> !irq_o); // R9
  AST_NOT_AHEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (wdata_i[CNT_W-1:0] <= count_i)) |=> !irq_o ##1 !irq_o); // R10
  AST_IRQ_ON_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !we_i && count_i == tgt) |=> irq_o); // R8
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int CNT_W  = 63,
  localparam int DATA_W = CNT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic              sel_i,
  input  logic [1:0]        priv_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [1:0]        fault_o,
  output logic              irq_o
);
  fault_e            fault;
  logic              cnt_we, cmp_we, rd_ok, lock;
  logic [CNT_W-1:0]  count;
  logic [CNT_W:0]    cmp_reg;

  tick_access_ctrl u_ctrl (
    .req_i    (req_i),
    .wr_i     (wr_i),
    .sel_i    (sel_i),
    .priv_i   (priv_i),
    .lock_i   (lock),
    .fault_o  (fault),
    .cnt_we_o (cnt_we),
    .cmp_we_o (cmp_we),
    .rd_ok_o  (rd_ok)
  );

  tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cnt_we),
    .wdata_i (wdata_i),
    .count_o (count),
    .lock_o  (lock)
  );

  tick_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cmp_we),
    .wdata_i (wdata_i),
    .count_i (count),
    .cmp_o   (cmp_reg),
    .irq_o   (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_ok) rdata_o = (sel_i == SEL_CMP) ? cmp_reg : {lock, count};
  end

  assign fault_o = fault;

  always_comb begin
    if (fault_o != 2'd0) AST_FAULT_ZERO_DATA: assert (rdata_o == '0); // R12
  end

  AST_DENIED_CNT_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && wr_i && sel_i == SEL_CNT && !priv_i[1]) |=> $stable(lock)); // R4
  AST_DENIED_CMP_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && wr_i && sel_i == SEL_CMP && priv_i == 2'd0) |=> $stable(cmp_reg)); // R6
endmodule

// File: tb/tb_tick_timer.sv
module tb_tick_timer;
  localparam logic [1:0] USR = 2'd0, SUP = 2'd1, HYP = 2'd2;
  localparam logic CNT = 1'b0, CMP = 1'b1;
  localparam logic [63:0] DIS = 64'h8000_0000_0000_0000;

  // {priv[1:0], sel, wr, expected fault[1:0]}
  localparam logic [5:0] VEC [12] = '{
    6'b00_0_0_00, 6'b00_0_1_01, 6'b00_1_0_01, 6'b00_1_1_01,
    6'b01_0_0_00, 6'b01_0_1_10, 6'b01_1_0_00, 6'b01_1_1_00,
    6'b10_0_0_00, 6'b10_0_1_00, 6'b10_1_0_00, 6'b10_1_1_00
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req = 1'b0, wr = 1'b0, sel = 1'b0;
  logic [1:0] priv = 2'd0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic [1:0]  fault;
  logic        irq;
  logic [63:0] cap_rd;
  logic [1:0]  cap_f;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tick_timer dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .wr_i(wr), .sel_i(sel),
    .priv_i(priv), .wdata_i(wdata), .rdata_o(rdata), .fault_o(fault), .irq_o(irq)
  );

  task automatic check(input string req_id, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req_id, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] p, input logic s, input logic w, input logic [63:0] d);
    @(negedge clk);
    req = 1'b1; priv = p; sel = s; wr = w; wdata = d;
    #1;
    cap_rd = rdata; cap_f = fault;
  endtask

  task automatic op(input logic [1:0] p, input logic s, input logic w, input logic [63:0] d);
    drive(p, s, w, d);
    @(posedge clk); #1;
    req = 1'b0; wr = 1'b0;
  endtask

  task automatic probe(input logic [1:0] p, input logic s, input logic w, input logic [63:0] d);
    drive(p, s, w, d);
    #1 req = 1'b0; wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] c;
    // R1 reset state, probed while reset is held
    repeat (3) @(negedge clk);
    probe(SUP, CNT, 1'b0, '0);
    check("R1 count", cap_rd, 64'd0);
    probe(SUP, CMP, 1'b0, '0);
    check("R1 compare", cap_rd, DIS);
    check("R1 irq", {63'd0, irq}, 64'd0);
    @(negedge clk); rst_ni = 1'b1;

    // R12 idle
    #1 check("R12 idle fault", {62'd0, fault}, 64'd0);
    check("R12 idle data", rdata, 64'd0);

    // R4 R5 R6 fault decode table, no edge committed
    foreach (VEC[i]) begin
      probe(VEC[i][5:4], VEC[i][3], VEC[i][2], 64'hFFFF);
      check($sformatf("R4/R5/R6 row %0d fault", i), {62'd0, cap_f}, {62'd0, VEC[i][1:0]});
      if (cap_f != 2'd0) check($sformatf("R12 row %0d data", i), cap_rd, 64'd0);
    end

    // R3 load and read back, R2 stepping
    op(HYP, CNT, 1'b1, 64'h0000_0000_0000_1234);
    op(SUP, CNT, 1'b0, '0);
    check("R3 load", cap_rd, 64'h1234);
    op(SUP, CNT, 1'b0, '0);
    check("R2 step", cap_rd, 64'h1235);
    op(HYP, CNT, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF);
    op(SUP, CNT, 1'b0, '0);
    check("R2 max", cap_rd, 64'h7FFF_FFFF_FFFF_FFFF);
    op(SUP, CNT, 1'b0, '0);
    check("R2 wrap", cap_rd, 64'd0);

    // R3 lock flag and R5 locked user read
    op(HYP, CNT, 1'b1, DIS | 64'd5);
    op(SUP, CNT, 1'b0, '0);
    check("R3 flag in bit 63", cap_rd, DIS | 64'd5);
    op(USR, CNT, 1'b0, '0);
    check("R5 locked fault", {62'd0, cap_f}, 64'd2);
    check("R5 locked data", cap_rd, 64'd0);

    // R4 denied writes leave count and flag intact
    op(HYP, CNT, 1'b1, 64'd100);
    op(SUP, CNT, 1'b1, 64'd999);
    check("R4 supervisor fault", {62'd0, cap_f}, 64'd2);
    op(USR, CNT, 1'b1, DIS | 64'd7);
    check("R4 user fault", {62'd0, cap_f}, 64'd1);
    op(USR, CNT, 1'b0, '0);
    check("R4 count kept, R5 unlocked user read", cap_rd, 64'd102);

    // R6 denied compare write, R11 readback
    op(SUP, CMP, 1'b1, DIS | 64'd77);
    op(USR, CMP, 1'b1, 64'd5);
    op(SUP, CMP, 1'b0, '0);
    check("R6 write discarded / R11 readback", cap_rd, DIS | 64'd77);

    // R8 arm and fire
    op(HYP, CNT, 1'b1, 64'd0);
    op(SUP, CMP, 1'b1, 64'd30);
    op(SUP, CNT, 1'b0, '0);
    c = cap_rd;
    check("R8 count before wait", c, 64'd1);
    for (int i = 1; i <= 30 - int'(c) + 1; i++) begin
      @(negedge clk);
      if (i == 30 - int'(c))     check("R8 irq low at match cycle", {63'd0, irq}, 64'd0);
      if (i == 30 - int'(c) + 1) check("R8 irq raised", {63'd0, irq}, 64'd1);
    end
    // R9 sticky, then cleared by a compare write
    repeat (5) @(negedge clk);
    check("R9 sticky", {63'd0, irq}, 64'd1);
    op(SUP, CMP, 1'b1, DIS | 64'd30);
    @(negedge clk);
    check("R9 cleared by write", {63'd0, irq}, 64'd0);

    // R7 disable cancels an armed compare
    op(HYP, CNT, 1'b1, 64'd0);
    op(SUP, CMP, 1'b1, 64'd20);
    op(SUP, CMP, 1'b1, DIS | 64'd20);
    repeat (30) @(negedge clk);
    check("R7 cancelled", {63'd0, irq}, 64'd0);

    // R10 target behind and equal
    op(HYP, CNT, 1'b1, 64'd50);
    op(SUP, CMP, 1'b1, 64'd20);
    repeat (40) @(negedge clk);
    check("R10 behind", {63'd0, irq}, 64'd0);
    op(HYP, CNT, 1'b1, 64'd100);
    op(SUP, CMP, 1'b1, 64'd100);
    repeat (20) @(negedge clk);
    check("R10 equal", {63'd0, irq}, 64'd0);
    op(HYP, CMP, 1'b0, '0);
    check("R11 hyper readback", cap_rd, 64'd100);

    finish_run();
  end
endmodule